// File: doc/BRIEF.md
# Priority Clock Reference Selector

This block watches a set of candidate reference clocks (fourteen by default) and names the one that should drive a downstream timing loop. For every input, two monitors outside the block report whether the clock is toggling and whether its frequency sits within limits. The block turns those two flags into a qualified status. An input is qualified only after it has been good for a programmable run of consecutive monitor periods, and it loses that status at once when either flag drops.

Among the qualified inputs, the block picks the one with the numerically smallest non-zero priority from a register-style table. A priority of zero takes an input out of the running, and a tie goes to the lower input index. When no input qualifies after a lock, a mode bit chooses between holdover, which keeps the last index so the loop can hold its frequency, and squelch, which also asserts a control that disables the output. From reset, before any input qualifies, the block reports free-run.

Top module: `refsel_top`

## Requirements
- R1: An input becomes qualified only after `mon_tick` has been seen high in `qual_len` consecutive cycles in which both `act_ok[i]` and `freq_ok[i]` were high (a `qual_len` of 0 counts as 1). Qualification registers on the edge that samples the last such tick.
- R2: In any cycle where `act_ok[i]` or `freq_ok[i]` is low, input i loses qualification on the next edge and its run count restarts from zero.
- R3: The selection is the qualified input whose priority `prio_tbl[4i+3:4i]` has the smallest value, with 1 as the best.
- R4: An input whose priority field is 0 is never selected.
- R5: When qualified inputs share the best priority, the lowest input index is selected.
- R6: `sel_state` is encoded as 2'b00 free-run, 2'b01 locked, 2'b10 holdover and 2'b11 squelched. After reset the outputs are free-run, `sel_idx` 0, `sel_change` 0 and `squelch` 0.
- R7: When the state is locked and no input is qualified, the next state is holdover if `squelch_mode` is 0 and squelched if it is 1. While in either state, the state follows `squelch_mode`, `sel_idx` keeps the last selection, and `squelch` is high only when the state is squelched.
- R8: From holdover or squelched, the state returns to locked on the edge after any input is qualified.
- R9: `sel_idx` and `sel_state` update on the clock edge after the qualification that causes them. `sel_change` is high for one cycle together with each new selection or each entry to locked.
- R10: Free-run persists until the first qualification, and the state never returns to free-run without a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_tick | input | 1 | One-cycle strobe marking the end of a monitor period |
| act_ok | input | 14 | Per-input activity good flag |
| freq_ok | input | 14 | Per-input frequency good flag |
| prio_tbl | input | 56 | Priority table: 4 bits per input, input i at [4i+3:4i], 0 disables |
| qual_len | input | 4 | Good periods needed for qualification (0 treated as 1) |
| squelch_mode | input | 1 | 0 selects holdover, 1 selects squelch when all inputs fail |
| sel_idx | output | 4 | Index of the selected input |
| sel_state | output | 2 | Selector state |
| squelch | output | 1 | Output disable control, high while squelched |
| sel_change | output | 1 | One-cycle strobe on each new selection or entry to locked |

## Verification
On every cycle, the assertions check these rules: a dropped flag clears qualification on the next edge, a new qualification appears only just after a good tick, the arbiter names only a qualified input whose priority is non-zero, and a better candidate reaches `sel_idx` one edge later with `sel_change` high. They also check that any qualified input forces locked, that the held index stays still in holdover and squelch, and that free-run is never re-entered. The bench scenarios are the only way to show the count of consecutive periods, the choice of the strictly best priority, the lower-index rule on ties, and the mode-dependent fallback. To cover these, a cycle-level model built from the requirements runs under random flag, tick and table changes, alongside directed cases.

// File: rtl/refsel_pkg.sv
// Package: shared types for the reference selector.
// Assumes: nothing; holds the state encoding that appears on sel_state.
package refsel_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'b00,
        ST_LOCK  = 2'b01,
        ST_HOLD  = 2'b10,
        ST_SQL   = 2'b11
    } sel_state_t;

endpackage

// File: rtl/refsel_qual.sv
// Module: refsel_qual
// Qualifies one reference input. It counts consecutive good monitor periods
// and sets the qualified flag once the count reaches the threshold. Any cycle
// with a bad flag clears both the count and the qualified flag.
// Assumes: act/freq flags are synchronous to clk; tick is a one-cycle strobe.
module refsel_qual #(
    parameter int QUAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              act,
    input  logic              freq,
    input  logic [QUAL_W-1:0] thr_len,
    output logic              qual
);
    localparam int CW = QUAL_W + 1;

    logic          good;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] thr;
    logic          qual_q;

    assign good = act & freq;

    // Threshold with zero treated as one period.
    always_comb begin
        thr    = (thr_len == '0) ? CW'(1) : CW'(thr_len);
        cnt_nx = cnt_q + CW'(1);
    end

    // Run counter and qualified flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!good) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (tick && !qual_q) begin
            cnt_q <= cnt_nx;
            if (cnt_nx >= thr) begin
                qual_q <= 1'b1;
            end
        end
    end

    assign qual = qual_q;

    // R2: a bad flag removes qualification on the next edge.
    p_drop_on_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !good |=> !qual_q);

    // R1: qualification only appears right after a good tick.
    p_rise_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_q) |-> ($past(tick) && $past(good)));

endmodule

// File: rtl/refsel_arb.sv
// Module: refsel_arb
// Combinational priority arbiter. Among qualified inputs with a non-zero
// priority it names the smallest priority value; ties go to the lower index.
// Assumes: priority fields are packed 4-bit-wide at PRIO_W*i.
module refsel_arb #(
    parameter int N_IN   = 14,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]        qual,
    input  logic [N_IN*PRIO_W-1:0] prio,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] cur_p;

    // Scan from the top index down so that the lower index wins a tie.
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        best_p = '1;
        cur_p  = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            cur_p = prio[i*PRIO_W +: PRIO_W];
            if (qual[i] && (cur_p != '0) && (!any || cur_p <= best_p)) begin
                any    = 1'b1;
                idx    = IDX_W'(i);
                best_p = cur_p;
            end
        end
    end

    // R4: the named input is qualified and enabled.
    always_comb begin
        if (any) begin
            p_pick_enabled_r4: assert (qual[idx] && prio[idx*PRIO_W +: PRIO_W] != '0);
        end
    end

endmodule

// File: rtl/refsel_fsm.sv
// Module: refsel_fsm
// Selector state machine. It registers the arbiter's choice and tracks the
// free-run, locked, holdover and squelched states.
// Assumes: any/idx come combinationally from the arbiter in the same cycle.
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [IDX_W-1:0] best_idx,
    input  logic             sq_mode,
    output logic [IDX_W-1:0] sel_idx,
    output sel_state_t       state,
    output logic             chg
);
    sel_state_t       state_q;
    logic [IDX_W-1:0] sel_q;
    logic             chg_q;

    // State, held selection and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            sel_q   <= '0;
            chg_q   <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (any) begin
                state_q <= ST_LOCK;
                if (state_q != ST_LOCK || best_idx != sel_q) begin
                    sel_q <= best_idx;
                    chg_q <= 1'b1;
                end
            end else if (state_q != ST_FREE) begin
                state_q <= sq_mode ? ST_SQL : ST_HOLD;
            end
        end
    end

    assign sel_idx = sel_q;
    assign state   = state_q;
    assign chg     = chg_q;

    // R8: any qualified input forces locked on the next edge.
    p_lock_on_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any |=> state_q == ST_LOCK);

    // R9: a different best candidate is taken one edge later with a strobe.
    p_move_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (any && best_idx != sel_q) |=> (sel_q == $past(best_idx) && chg_q));

    // R7: holdover and squelch keep the last index.
    p_hold_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD || state_q == ST_SQL) |-> $stable(sel_q));

    // R10: free-run is never re-entered without reset.
    p_no_free_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_FREE |=> state_q != ST_FREE);

endmodule

// File: rtl/refsel_top.sv
// Module: refsel_top
// Priority clock reference selector. One qualifier per input feeds a
// priority arbiter, whose result the state machine registers.
// Assumes: monitor flags and tick are synchronous to clk; the table is static
// or changed at any time (each change takes effect through the arbiter).
module refsel_top
    import refsel_pkg::*;
#(
    parameter int N_IN   = 14,
    parameter int PRIO_W = 4,
    parameter int QUAL_W = 4,
    parameter int IDX_W  = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mon_tick,
    input  logic [N_IN-1:0]        act_ok,
    input  logic [N_IN-1:0]        freq_ok,
    input  logic [N_IN*PRIO_W-1:0] prio_tbl,
    input  logic [QUAL_W-1:0]      qual_len,
    input  logic                   squelch_mode,
    output logic [IDX_W-1:0]       sel_idx,
    output logic [1:0]             sel_state,
    output logic                   squelch,
    output logic                   sel_change
);
    logic [N_IN-1:0]  qual_vec;
    logic             arb_any;
    logic [IDX_W-1:0] arb_idx;
    sel_state_t       st;

    // One qualifier per reference input.
    for (genvar g = 0; g < N_IN; g++) begin : g_qual
        refsel_qual #(.QUAL_W(QUAL_W)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (mon_tick),
            .act     (act_ok[g]),
            .freq    (freq_ok[g]),
            .thr_len (qual_len),
            .qual    (qual_vec[g])
        );
    end

    refsel_arb #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .qual (qual_vec),
        .prio (prio_tbl),
        .any  (arb_any),
        .idx  (arb_idx)
    );

    refsel_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any      (arb_any),
        .best_idx (arb_idx),
        .sq_mode  (squelch_mode),
        .sel_idx  (sel_idx),
        .state    (st),
        .chg      (sel_change)
    );

    assign sel_state = st;
    assign squelch   = (st == ST_SQL);

endmodule

// File: tb/sim_refsel_top.sv
// Bench for refsel_top: directed corner cases followed by seeded random
// stimulus, compared against a cycle-level model built from the requirements.
module sim_refsel_top;
    localparam int N  = 14;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_tick = 1'b0;
    logic [N-1:0]  act_ok = '0;
    logic [N-1:0]  freq_ok = '0;
    logic [N*PW-1:0] prio_tbl = '0;
    logic [3:0]    qual_len = 4'd1;
    logic          squelch_mode = 1'b0;
    logic [3:0]    sel_idx;
    logic [1:0]    sel_state;
    logic          squelch;
    logic          sel_change;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    refsel_top u0 (
        .clk(clk), .rst_n(rst_n), .mon_tick(mon_tick), .act_ok(act_ok),
        .freq_ok(freq_ok), .prio_tbl(prio_tbl), .qual_len(qual_len),
        .squelch_mode(squelch_mode), .sel_idx(sel_idx), .sel_state(sel_state),
        .squelch(squelch), .sel_change(sel_change)
    );

    // Reference model state.
    bit       m_q [N];
    int       m_cnt [N];
    logic [1:0] m_st;
    int       m_sel;
    bit       m_chg;

    function automatic int best_of(input logic [N*PW-1:0] pt, output bit found);
        int b = 0;
        int bp = 99;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int p = int'(pt[i*PW +: PW]);
            if (m_q[i] && p != 0 && p < bp) begin
                bp = p;
                b = i;
                found = 1'b1;
            end
        end
        return b;
    endfunction

    // Model update on each edge, using inputs as they stand at the edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_q[i] = 0; m_cnt[i] = 0; end
            m_st = 2'b00; m_sel = 0; m_chg = 0;
        end else begin
            bit f;
            int b;
            int thr;
            b = best_of(prio_tbl, f);
            m_chg = 0;
            if (f) begin
                if (m_st != 2'b01 || b != m_sel) begin m_sel = b; m_chg = 1; end
                m_st = 2'b01;
            end else if (m_st != 2'b00) begin
                m_st = squelch_mode ? 2'b11 : 2'b10;
            end
            thr = (qual_len == 0) ? 1 : int'(qual_len);
            for (int i = 0; i < N; i++) begin
                if (!(act_ok[i] && freq_ok[i])) begin
                    m_q[i] = 0; m_cnt[i] = 0;
                end else if (mon_tick && !m_q[i]) begin
                    m_cnt[i]++;
                    if (m_cnt[i] >= thr) m_q[i] = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input int e_sel, input int e_st, input int e_chg, input string req);
        chk(int'(sel_idx) == e_sel, {req, " sel_idx"}, int'(sel_idx), e_sel);
        chk(int'(sel_state) == e_st, {req, " sel_state"}, int'(sel_state), e_st);
        chk(int'(sel_change) == e_chg, {req, " sel_change"}, int'(sel_change), e_chg);
        chk(squelch == (e_st == 3), {req, " squelch"}, int'(squelch), int'(e_st == 3));
    endtask

    task automatic setp(input int i, input int p);
        prio_tbl[i*PW +: PW] = PW'(p);
    endtask

    task automatic pulse_tick();
        mon_tick = 1'b1;
        @(negedge clk);
        mon_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out(0, 0, 0, "R6 reset");

        // Inputs 2 and 5 tie on priority 3, input 9 disabled by priority 0.
        setp(2, 3); setp(5, 3); setp(9, 0); setp(7, 1);
        qual_len = 4'd3;
        act_ok[2] = 1; freq_ok[2] = 1; act_ok[5] = 1; freq_ok[5] = 1;
        act_ok[9] = 1; freq_ok[9] = 1;
        pulse_tick(); pulse_tick();
        @(negedge clk);
        chk_out(0, 0, 0, "R1 R10 two of three periods");
        pulse_tick();
        chk(int'(sel_state) == 0, "R9 not yet selected", int'(sel_state), 0);
        @(negedge clk);
        chk_out(2, 1, 1, "R5 R9 tie to lower index");
        @(negedge clk);
        chk_out(2, 1, 0, "R9 strobe one cycle");

        // Only the disabled input stays good: nothing is selected.
        act_ok[2] = 0; act_ok[5] = 0;
        @(negedge clk); @(negedge clk);
        chk_out(2, 2, 0, "R4 R7 disabled not chosen, holdover");
        squelch_mode = 1'b1;
        @(negedge clk);
        chk_out(2, 3, 0, "R7 squelch follows mode");

        // A single tick with a bad frequency flag does not count.
        qual_len = 4'd1;
        act_ok[7] = 1; freq_ok[7] = 0;
        pulse_tick();
        @(negedge clk);
        chk_out(2, 3, 0, "R1 bad frequency blocks");
        freq_ok[7] = 1;
        pulse_tick();
        @(negedge clk);
        chk_out(7, 1, 1, "R8 R3 recover to best");

        // Lower-priority input qualifies: no change.
        act_ok[2] = 1; setp(2, 9);
        pulse_tick(); @(negedge clk);
        chk_out(7, 1, 0, "R3 worse priority ignored");
        // Best input drops: move to the remaining one.
        freq_ok[7] = 0;
        @(negedge clk); @(negedge clk);
        chk_out(2, 1, 1, "R2 drop moves selection");

        // Random phase checked against the model.
        squelch_mode = 1'b0;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            chk_out(m_sel, int'(m_st), int'(m_chg), "R3 R5 R7 R9 random");
            mon_tick = ($urandom_range(0, 2) == 0);
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 47) == 0) act_ok[i] = ~act_ok[i];
                if ($urandom_range(0, 47) == 0) freq_ok[i] = ~freq_ok[i];
            end
            if ($urandom_range(0, 99) == 0) setp($urandom_range(0, N-1), $urandom_range(0, 15));
            if ($urandom_range(0, 299) == 0) squelch_mode = ~squelch_mode;
            if ($urandom_range(0, 399) == 0) qual_len = 4'($urandom_range(0, 4));
            if ($urandom_range(0, 999) == 0) begin
                act_ok = '0;
            end
        end
        @(negedge clk);
        chk_out(m_sel, int'(m_st), int'(m_chg), "R8 R10 random end");
        finish_run();
    end
endmodule